// File: doc/BRIEF.md
# Bus Watchpoint Trigger Comparator

This block watches a sampled processor-side bus, made of a 32-bit address and 26 active-low control lines, and raises a trigger when the bus value in a cycle matches a pattern that software has set up. There are two watchpoints with the same layout. Each has its own control pattern, address pattern, address mask and control mask. The comparison runs in every clock cycle. The block only samples the bus and never drives it.

For each control line, software picks whether a match needs the line asserted (low) or negated (high). Multi-bit fields, such as the 5-bit transfer type and the 3-bit transfer size, match when the sampled field equals the programmed field. Setting a mask bit takes that address or control bit out of the comparison. Each watchpoint has an enable bit, so the all-zero reset state never fires. Each hit output is a register: it goes high in the cycle after a matching bus sample.

Software reaches the registers through a word-indexed write strobe and a combinational read port. The index is {watchpoint, slot}. The slots are control pattern (0), address pattern (1), address mask (2) and control mask with enable (3).

Top module: `bwp_top`

## Requirements
- R1: After reset, every register word reads 0x0000_0000 and both hit outputs are low.
- R2: Bits 31..26 of a control-pattern word (slot 0) read as zero whatever was written; bits 25..0 read back what was written.
- R3: The address pattern (slot 1) and the address mask (slot 2) read back the full 32-bit value last written. A watchpoint's words sit at index 4*w + slot, so a write to one watchpoint leaves the other unchanged.
- R4: For each unmasked control bit, a programmed 0 matches a sampled 0 (asserted, active low) and a programmed 1 matches a sampled 1 (negated).
- R5: Each unmasked address bit must equal the address pattern bit for a hit.
- R6: A mask bit of 1 in the address mask or the control mask removes that bit from the comparison.
- R7: Hit w is high in the cycle after a cycle in which watchpoint w was enabled and every unmasked bit matched, and it is low otherwise. A single matching cycle gives a one-cycle pulse.
- R8: When enable (slot 3, bit 31) is 0, that watchpoint's hit stays low in the following cycle whatever the bus carries. A write of 0 to enable in the same cycle as a matching sample still lets the hit from that sample through.
- R9: The two watchpoints compare independently, and they can hit in the same cycle.
- R10: In slot 3, bits 25..0 are the control mask, bit 31 is enable and bits 30..26 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index {watchpoint, slot} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| bus_addr | input | 32 | Sampled bus address |
| bus_ctl | input | 26 | Sampled active-low bus control lines |
| wp_hit | output | 2 | Registered hit per watchpoint |

## Verification
The two watchpoints can fire in the same cycle. They are set with different masks: one tests address plus transfer start, the other tests only the burst flag and the transfer-size field. Vectors are chosen so that each can hit alone, both can hit together, or neither hits. Each hit bit is judged one cycle after its bus sample against the value expected from the requirements. Random samples near both patterns are then compared with a bench model of the masked, polarity-aware comparison.

// File: rtl/bwp_pkg.sv
package bwp_pkg;

    localparam int REG_W        = 32;
    localparam int ADDR_W       = 32;
    localparam int CTL_W        = 26;
    localparam int SLOT_W       = 2;
    localparam int WORDS_PER_WP = 1 << SLOT_W;
    localparam int EN_BIT       = REG_W - 1;

    // Control line positions that neighbours decode (active low on the bus)
    localparam int CTL_TS_BIT   = 21;
    localparam int CTL_TT_LSB   = 16;
    localparam int CTL_TT_W     = 5;
    localparam int CTL_BST_BIT  = 15;
    localparam int CTL_SIZ_LSB  = 12;
    localparam int CTL_SIZ_W    = 3;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_CPAT  = 2'd0,
        SLOT_APAT  = 2'd1,
        SLOT_AMASK = 2'd2,
        SLOT_CMASK = 2'd3
    } slot_e;

    typedef struct packed {
        logic              en;
        logic [CTL_W-1:0]  cmask;
        logic [ADDR_W-1:0] amask;
        logic [ADDR_W-1:0] apat;
        logic [CTL_W-1:0]  cpat;
    } wp_cfg_t;

    // A bit agrees when it equals the pattern or is masked out
    function automatic logic addr_agree(input logic [ADDR_W-1:0] pat,
                                        input logic [ADDR_W-1:0] msk,
                                        input logic [ADDR_W-1:0] val);
        return &(~(pat ^ val) | msk);
    endfunction

    function automatic logic ctl_agree(input logic [CTL_W-1:0] pat,
                                       input logic [CTL_W-1:0] msk,
                                       input logic [CTL_W-1:0] val);
        return &(~(pat ^ val) | msk);
    endfunction

    function automatic logic [REG_W-1:0] read_word(input wp_cfg_t c, input slot_e s);
        logic [REG_W-1:0] w;
        w = '0;
        case (s)
            SLOT_CPAT:  w[CTL_W-1:0] = c.cpat;
            SLOT_APAT:  w = c.apat;
            SLOT_AMASK: w = c.amask;
            SLOT_CMASK: begin
                w[CTL_W-1:0] = c.cmask;
                w[EN_BIT]    = c.en;
            end
            default:    w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/bwp_regs.sv
module bwp_regs
    import bwp_pkg::*;
#(
    parameter int NUM_WP = 2,
    parameter int IDX_W  = $clog2(NUM_WP) + SLOT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IDX_W-1:0]        addr,
    input  logic [REG_W-1:0]        wdata,
    output logic [REG_W-1:0]        rdata,
    output wp_cfg_t [NUM_WP-1:0]    cfg
);

    localparam int WSEL_W = IDX_W - SLOT_W;

    logic [WSEL_W-1:0] wsel;
    slot_e             slot;
    logic              spare_unused;

    assign wsel         = addr[IDX_W-1:SLOT_W];
    assign slot         = slot_e'(addr[SLOT_W-1:0]);
    assign spare_unused = ^wdata[REG_W-2:CTL_W];

    for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
        localparam logic [WSEL_W-1:0] MY_SEL = WSEL_W'(g);
        logic hit_me;
        assign hit_me = we && (wsel == MY_SEL);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[g] <= '0;
            end else if (hit_me) begin
                case (slot)
                    SLOT_CPAT:  cfg[g].cpat  <= wdata[CTL_W-1:0];
                    SLOT_APAT:  cfg[g].apat  <= wdata[ADDR_W-1:0];
                    SLOT_AMASK: cfg[g].amask <= wdata[ADDR_W-1:0];
                    SLOT_CMASK: begin
                        cfg[g].cmask <= wdata[CTL_W-1:0];
                        cfg[g].en    <= wdata[EN_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_WP; k++) begin
            if (wsel == WSEL_W'(k)) rdata = read_word(cfg[k], slot);
        end
    end

endmodule

// File: rtl/bwp_match.sv
module bwp_match
    import bwp_pkg::*;
(
    input  wp_cfg_t           cfg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTL_W-1:0]  bus_ctl,
    output logic              match
);

    logic addr_ok;
    logic ctl_ok;

    assign addr_ok = addr_agree(cfg.apat, cfg.amask, bus_addr);
    assign ctl_ok  = ctl_agree(cfg.cpat, cfg.cmask, bus_ctl);
    assign match   = addr_ok & ctl_ok;

endmodule

// File: rtl/bwp_top.sv
module bwp_top
    import bwp_pkg::*;
#(
    parameter int NUM_WP = 2,
    parameter int IDX_W  = $clog2(NUM_WP) + SLOT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_addr,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CTL_W-1:0]   bus_ctl,
    output logic [NUM_WP-1:0]  wp_hit
);

    wp_cfg_t [NUM_WP-1:0]           cfg_w;
    logic [NUM_WP-1:0]              match_w;
    logic [NUM_WP-1:0]              en_w;
    logic [NUM_WP-1:0][ADDR_W-1:0]  apat_w;
    logic [NUM_WP-1:0][ADDR_W-1:0]  amask_w;

    bwp_regs #(.NUM_WP(NUM_WP), .IDX_W(IDX_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg_w)
    );

    for (genvar g = 0; g < NUM_WP; g++) begin : g_cmp
        bwp_match u_match (
            .cfg      (cfg_w[g]),
            .bus_addr (bus_addr),
            .bus_ctl  (bus_ctl),
            .match    (match_w[g])
        );
        assign en_w[g]    = cfg_w[g].en;
        assign apat_w[g]  = cfg_w[g].apat;
        assign amask_w[g] = cfg_w[g].amask;
    end

    always_ff @(posedge clk) begin
        if (rst) wp_hit <= '0;
        else     wp_hit <= en_w & match_w;
    end

endmodule

// File: rtl/bwp_chk.sv
module bwp_chk
    import bwp_pkg::*;
#(
    parameter int NUM_WP = 2,
    parameter int IDX_W  = $clog2(NUM_WP) + SLOT_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [IDX_W-1:0]              cfg_addr,
    input  logic [REG_W-1:0]              cfg_rdata,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [NUM_WP-1:0]             wp_hit,
    input  logic [NUM_WP-1:0]             en,
    input  logic [NUM_WP-1:0][ADDR_W-1:0] apat,
    input  logic [NUM_WP-1:0][ADDR_W-1:0] amask,
    input  logic [NUM_WP-1:0]             match
);

    // R1
    reset_clears_hit_chk: assert property (@(posedge clk) rst |=> (wp_hit == '0));

    // R2
    cpat_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr[SLOT_W-1:0] == SLOT_CPAT) |-> (cfg_rdata[REG_W-1:CTL_W] == '0));

    // R10
    cmask_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr[SLOT_W-1:0] == SLOT_CMASK) |-> (cfg_rdata[REG_W-2:CTL_W] == '0));

    for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
        // R8
        hit_gated_off_chk: assert property (@(posedge clk) disable iff (rst)
            !en[g] |=> !wp_hit[g]);
        // R7
        hit_follows_match_chk: assert property (@(posedge clk) disable iff (rst)
            wp_hit[g] |-> $past(match[g]));
        // R7
        hit_on_match_chk: assert property (@(posedge clk) disable iff (rst)
            (en[g] && match[g]) |=> wp_hit[g]);
        // R5
        hit_addr_agree_chk: assert property (@(posedge clk) disable iff (rst)
            wp_hit[g] |-> $past(((bus_addr ^ apat[g]) & ~amask[g]) == '0));
    end

endmodule

bind bwp_top bwp_chk #(.NUM_WP(NUM_WP), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .bus_addr  (bus_addr),
    .wp_hit    (wp_hit),
    .en        (en_w),
    .apat      (apat_w),
    .amask     (amask_w),
    .match     (match_w)
);

// File: tb/sim_bwp_top.sv
module sim_bwp_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {bus_addr, bus_ctl(26), expected hit(2)}
    localparam logic [59:0] VEC [NVEC] = '{
        {32'h1000_0040, 26'h3FF_FFFF, 2'b00},
        {32'h1000_0045, 26'h3DF_FFFF, 2'b01},
        {32'h1000_0050, 26'h3DF_FFFF, 2'b00},
        {32'h0000_0000, 26'h000_A000, 2'b10},
        {32'h1000_004F, 26'h000_A000, 2'b11},
        {32'h1000_004F, 26'h000_2000, 2'b01},
        {32'h9000_0040, 26'h000_A000, 2'b10},
        {32'hFFFF_FFFF, 26'h3DF_AFFF, 2'b10}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] bus_addr = '0;
    logic [25:0] bus_ctl = '1;
    logic [1:0]  wp_hit;

    int checks = 0;
    int failures = 0;

    // bench copy of the programmed configuration
    logic [25:0] m_cpat [2];
    logic [25:0] m_cmask[2];
    logic [31:0] m_apat [2];
    logic [31:0] m_amask[2];
    logic        m_en   [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    bwp_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_addr(bus_addr), .bus_ctl(bus_ctl), .wp_hit(wp_hit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = 3'(idx);
        #1 d = cfg_rdata;
    endtask

    task automatic program_wp(input int w, input logic [25:0] cp, input logic [31:0] ap,
                              input logic [31:0] am, input logic [25:0] cm, input logic en);
        wr(4*w + 0, {6'b0, cp});
        wr(4*w + 1, ap);
        wr(4*w + 2, am);
        wr(4*w + 3, {en, 5'b0, cm});
        m_cpat[w] = cp; m_apat[w] = ap; m_amask[w] = am; m_cmask[w] = cm; m_en[w] = en;
    endtask

    // drive one bus sample, return hit seen in the next cycle
    task automatic sample(input logic [31:0] a, input logic [25:0] c, output logic [1:0] h);
        @(negedge clk);
        bus_addr = a; bus_ctl = c;
        @(negedge clk);
        h = wp_hit;
    endtask

    function automatic logic [1:0] model(input logic [31:0] a, input logic [25:0] c);
        logic [1:0] r;
        for (int w = 0; w < 2; w++) begin
            r[w] = m_en[w] && (((a ^ m_apat[w]) & ~m_amask[w]) == 0)
                           && (((c ^ m_cpat[w]) & ~m_cmask[w]) == 0);
        end
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [1:0]  h;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 hit", 32'(wp_hit), 32'h0);
        for (int i = 0; i < 8; i++) begin
            rd(i, d);
            chk("R1 word", d, 32'h0);
        end

        // R2 / R10 reserved bits, R3 readback and independence
        wr(0, 32'hFFFF_FFFF);
        rd(0, d); chk("R2 cpat", d, 32'h03FF_FFFF);
        wr(3, 32'hFFFF_FFFF);
        rd(3, d); chk("R10 cmask", d, 32'h83FF_FFFF);
        wr(5, 32'hA5C3_0F12);
        rd(5, d); chk("R3 apat wp1", d, 32'hA5C3_0F12);
        rd(1, d); chk("R3 apat wp0 untouched", d, 32'h0);
        wr(2, 32'h1234_5678);
        rd(2, d); chk("R3 amask", d, 32'h1234_5678);

        // vector table: R4 R5 R6 R9
        program_wp(0, 26'h000_0000, 32'h1000_0040, 32'h0000_000F, 26'h3DF_FFFF, 1'b1);
        program_wp(1, 26'h000_A000, 32'h2000_0000, 32'hFFFF_FFFF, 26'h3FF_0FFF, 1'b1);
        for (int i = 0; i < NVEC; i++) begin
            sample(VEC[i][59:28], VEC[i][27:2], h);
            chk("R5 R6 R9 vector", 32'(h), 32'(VEC[i][1:0]));
        end

        // R4 polarity: wp0 requires bit 0 negated (sampled 1)
        program_wp(0, 26'h000_0001, 32'h1000_0040, 32'hFFFF_FFFF, 26'h3FF_FFFE, 1'b1);
        sample(32'h0, 26'h000_0001, h); chk("R4 negated match", 32'(h[0]), 32'h1);
        sample(32'h0, 26'h000_0000, h); chk("R4 asserted no match", 32'(h[0]), 32'h0);
        program_wp(0, 26'h000_0000, 32'h1000_0040, 32'hFFFF_FFFF, 26'h3FF_FFFE, 1'b1);
        sample(32'h0, 26'h000_0000, h); chk("R4 asserted match", 32'(h[0]), 32'h1);

        // R7 one-cycle pulse timing
        sample(32'h0, 26'h000_0001, h);
        chk("R7 idle", 32'(h[0]), 32'h0);
        @(negedge clk);
        bus_ctl = 26'h000_0000;
        #1 chk("R7 not same cycle", 32'(wp_hit[0]), 32'h0);
        @(negedge clk);
        bus_ctl = 26'h000_0001;
        chk("R7 pulse high", 32'(wp_hit[0]), 32'h1);
        @(negedge clk);
        chk("R7 pulse ends", 32'(wp_hit[0]), 32'h0);

        // R8 enable gating, and disable in the same cycle as a match
        program_wp(0, 26'h000_0000, 32'h0, 32'hFFFF_FFFF, 26'h3FF_FFFF, 1'b0);
        sample(32'h0, 26'h000_0000, h); chk("R8 disabled", 32'(h[0]), 32'h0);
        program_wp(0, 26'h000_0000, 32'h0, 32'hFFFF_FFFF, 26'h3FF_FFFF, 1'b1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 32'h03FF_FFFF;
        @(negedge clk);
        cfg_we = 1'b0; m_en[0] = 1'b0;
        chk("R8 same-cycle hit passes", 32'(wp_hit[0]), 32'h1);
        @(negedge clk);
        chk("R8 gated next", 32'(wp_hit[0]), 32'h0);

        // random samples near both patterns against the model (R4 R5 R6 R9)
        program_wp(0, 26'h155_0000, 32'hC0DE_0000, 32'h0000_00FF, 26'h00F_FFFF, 1'b1);
        program_wp(1, 26'h000_5A5A, 32'h0000_1234, 32'hFFFF_0000, 26'h3FF_0000, 1'b1);
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            logic [25:0] c;
            logic [31:0] r1;
            logic [31:0] r2;
            r1 = $urandom; r2 = $urandom;
            if (i % 2 == 0) begin
                a = 32'hC0DE_0000 ^ (r1 & 32'h0100_01FF);
                c = 26'h155_0000 ^ (r2[25:0] & 26'h041_FFFF);
            end else begin
                a = 32'h0000_1234 ^ (r1 & 32'hFFFF_0011);
                c = 26'h000_5A5A ^ (r2[25:0] & 26'h3F0_0101);
            end
            sample(a, c, h);
            chk("R9 random model", 32'(h), 32'(model(a, c)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule